// File: doc/BRIEF.md
# Second-Level Interrupt Aggregator

This block gathers up to 32 interrupt sources into one parent interrupt line, through a small memory-mapped register bank. A build-time parameter picks one of two behaviours. In the latched variant, a rising edge on a source leaves a sticky pending bit. Software retires that bit by writing a one to an acknowledge register, and it can raise pending bits on its own through a force register. In the level variant, the pending view follows the live source inputs, and the acknowledge and force registers are absent, so the map is shorter.

Each source has its own enable gate. The gate is changed through two write-one registers: one masks bits and the other unmasks them. The current gate state can be read back. The parent line is a registered OR of every pending, unmasked bit. A driver normally unmasks the sources it owns, waits for the parent line, reads the pending and mask views, and then acknowledges the bits it has serviced.

Top module: `l2irq_ctrl`

## Requirements
- R1: After reset every mask bit is 1, every latched pending bit is 0, `irq_o` is 0 and `bus_rdata_o` is 0.
- R2: In latched mode (LEVEL_MODE=0), a 0-to-1 change on `src_i[n]` sets pending bit n at the next clock edge. The bit stays set after the source falls, and it reads as bit n of the word at offset 0x00.
- R3: In latched mode, a write to offset 0x08 clears each pending bit whose data bit is 1 and leaves the bits written as 0 unchanged.
- R4: In latched mode, a write to offset 0x04 sets each pending bit whose data bit is 1.
- R5: In latched mode, when a rising source edge and an acknowledge of the same bit fall in the same cycle, the bit stays set.
- R6: Ones written to the mask-set offset (0x10 latched, 0x08 level) set mask bits. Ones written to the mask-clear offset (0x14 latched, 0x0C level) clear them. Zero bits change nothing. The mask-status offset (0x0C latched, 0x04 level) reads 1 for each masked source.
- R7: `irq_o` is 1 in the cycle after any bit has pending=1 and mask=0, and 0 otherwise.
- R8: In level mode (LEVEL_MODE=1), offset 0x00 reads the `src_i` levels sampled at the read edge, and no acknowledge or force register exists.
- R9: Reads of unmapped offsets and of write-only registers return 0. Writes to offset 0x00, to the mask-status offset and to unmapped or misaligned offsets change no state.
- R10: Read data appears in the cycle after `bus_rd_i` and shows the state from before any write in the same cycle. In a cycle that follows no read, `bus_rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Interrupt source inputs |
| bus_addr_i | input | ADDR_W | Byte offset of the register access |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Parent interrupt |

## Verification
A wrong pending or mask bit shows up in two places. One is the parent line, exactly one cycle after the bad state forms. The other is the next read of the pending or mask-status word, which returns the bad state one cycle after the read strobe. Because every cycle compares both outputs against a bench model, a lost edge, a stray clear, or a write decoded to the wrong offset is reported within a cycle or two of the stimulus that exposes it.

// File: rtl/l2irq_pkg.sv
package l2irq_pkg;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_PEND,
      SEL_FORCE,
      SEL_ACK,
      SEL_MSTAT,
      SEL_MSET,
      SEL_MCLR
   } reg_sel_e;

   function automatic bit sel_readable(reg_sel_e s);
      return (s == SEL_PEND) || (s == SEL_MSTAT);
   endfunction

endpackage

// File: rtl/l2irq_decode.sv
module l2irq_decode
   import l2irq_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter bit LEVEL_MODE = 1'b0
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);

   generate
      if (ADDR_W < 5) begin : g_bad_addr
         $error("l2irq_decode: ADDR_W must be at least 5");
      end

      if (LEVEL_MODE) begin : g_level_map
         localparam logic [ADDR_W-1:0] OFS_PEND  = ADDR_W'(8'h00);
         localparam logic [ADDR_W-1:0] OFS_MSTAT = ADDR_W'(8'h04);
         localparam logic [ADDR_W-1:0] OFS_MSET  = ADDR_W'(8'h08);
         localparam logic [ADDR_W-1:0] OFS_MCLR  = ADDR_W'(8'h0C);
         always_comb begin
            unique case (addr)
               OFS_PEND:  sel = SEL_PEND;
               OFS_MSTAT: sel = SEL_MSTAT;
               OFS_MSET:  sel = SEL_MSET;
               OFS_MCLR:  sel = SEL_MCLR;
               default:   sel = SEL_NONE;
            endcase
         end
      end else begin : g_latched_map
         localparam logic [ADDR_W-1:0] OFS_PEND  = ADDR_W'(8'h00);
         localparam logic [ADDR_W-1:0] OFS_FORCE = ADDR_W'(8'h04);
         localparam logic [ADDR_W-1:0] OFS_ACK   = ADDR_W'(8'h08);
         localparam logic [ADDR_W-1:0] OFS_MSTAT = ADDR_W'(8'h0C);
         localparam logic [ADDR_W-1:0] OFS_MSET  = ADDR_W'(8'h10);
         localparam logic [ADDR_W-1:0] OFS_MCLR  = ADDR_W'(8'h14);
         always_comb begin
            unique case (addr)
               OFS_PEND:  sel = SEL_PEND;
               OFS_FORCE: sel = SEL_FORCE;
               OFS_ACK:   sel = SEL_ACK;
               OFS_MSTAT: sel = SEL_MSTAT;
               OFS_MSET:  sel = SEL_MSET;
               OFS_MCLR:  sel = SEL_MCLR;
               default:   sel = SEL_NONE;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/l2irq_pending.sv
module l2irq_pending #(
   parameter int NUM_SRC    = 32,
   parameter bit LEVEL_MODE = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src,
   input  logic [NUM_SRC-1:0] ack_vec,
   input  logic [NUM_SRC-1:0] force_vec,
   output logic [NUM_SRC-1:0] pend
);

   generate
      if (LEVEL_MODE) begin : g_level
         logic unused_ok;
         assign unused_ok = ^{ack_vec, force_vec, clk, rst_n};
         assign pend = src;
      end else begin : g_latched
         logic [NUM_SRC-1:0] prev_q;
         logic [NUM_SRC-1:0] pend_q;
         logic [NUM_SRC-1:0] rise;

         assign rise = src & ~prev_q;

         for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  prev_q[i] <= 1'b0;
                  pend_q[i] <= 1'b0;
               end else begin
                  prev_q[i] <= src[i];
                  if (rise[i] || force_vec[i]) begin
                     pend_q[i] <= 1'b1;
                  end else if (ack_vec[i]) begin
                     pend_q[i] <= 1'b0;
                  end
               end
            end
         end

         assign pend = pend_q;

         // R2: pending bits never drop without an acknowledge
         a_r2_sticky_pending : assert property (@(posedge clk) disable iff (!rst_n)
            (ack_vec == '0) |=> ((pend & $past(pend)) == $past(pend)));

         // R3: acknowledged bits without a competing set are cleared
         a_r3_ack_clears : assert property (@(posedge clk) disable iff (!rst_n)
            (ack_vec != '0) |=> ((pend & $past(ack_vec & ~rise & ~force_vec)) == '0));

         // R5: an edge coinciding with an acknowledge is kept
         a_r5_edge_beats_ack : assert property (@(posedge clk) disable iff (!rst_n)
            ((ack_vec & rise) != '0) |=>
               ((pend & $past(ack_vec & rise)) == $past(ack_vec & rise)));

         // R4: forced bits read as pending next cycle
         a_r4_force_sets : assert property (@(posedge clk) disable iff (!rst_n)
            (force_vec != '0) |=> ((pend & $past(force_vec)) == $past(force_vec)));
      end
   endgenerate

endmodule

// File: rtl/l2irq_mask.sv
module l2irq_mask #(
   parameter int NUM_SRC = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] set_vec,
   input  logic [NUM_SRC-1:0] clr_vec,
   output logic [NUM_SRC-1:0] mask
);

   logic [NUM_SRC-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '1;
      end else begin
         mask_q <= (mask_q | set_vec) & ~clr_vec;
      end
   end

   assign mask = mask_q;

   // R6: ones written to mask-set land as masked
   a_r6_mask_set : assert property (@(posedge clk) disable iff (!rst_n)
      ((set_vec != '0) && (clr_vec == '0)) |=> ((mask & $past(set_vec)) == $past(set_vec)));

   // R6: ones written to mask-clear land as enabled
   a_r6_mask_clr : assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec != '0) |=> ((mask & $past(clr_vec)) == '0));

   // R6: bits not named by a write hold their value
   a_r6_mask_hold : assert property (@(posedge clk) disable iff (!rst_n)
      ((set_vec == '0) && (clr_vec == '0)) |=> $stable(mask));

endmodule

// File: rtl/l2irq_ctrl.sv
module l2irq_ctrl
   import l2irq_pkg::*;
#(
   parameter int NUM_SRC    = 32,
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 8,
   parameter bit LEVEL_MODE = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic [ADDR_W-1:0]  bus_addr_i,
   input  logic               bus_wr_i,
   input  logic               bus_rd_i,
   input  logic [DATA_W-1:0]  bus_wdata_i,
   output logic [DATA_W-1:0]  bus_rdata_o,
   output logic               irq_o
);

   localparam int PAD_W = DATA_W - NUM_SRC;

   generate
      if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_width
         $error("l2irq_ctrl: NUM_SRC must lie in 1..DATA_W");
      end
   endgenerate

   reg_sel_e           sel;
   logic [NUM_SRC-1:0] wvec;
   logic [NUM_SRC-1:0] ack_vec;
   logic [NUM_SRC-1:0] force_vec;
   logic [NUM_SRC-1:0] mset_vec;
   logic [NUM_SRC-1:0] mclr_vec;
   logic [NUM_SRC-1:0] pend;
   logic [NUM_SRC-1:0] mask;
   logic [DATA_W-1:0]  rd_word;
   logic [DATA_W-1:0]  rdata_q;
   logic               irq_q;

   l2irq_decode #(
      .ADDR_W     (ADDR_W),
      .LEVEL_MODE (LEVEL_MODE)
   ) u_decode (
      .addr (bus_addr_i),
      .sel  (sel)
   );

   generate
      if (PAD_W > 0) begin : g_wr_narrow
         logic unused_hi;
         assign unused_hi = ^bus_wdata_i[DATA_W-1:NUM_SRC];
         assign wvec      = bus_wdata_i[NUM_SRC-1:0];
      end else begin : g_wr_full
         assign wvec = bus_wdata_i;
      end
   endgenerate

   assign ack_vec   = (bus_wr_i && sel == SEL_ACK)   ? wvec : '0;
   assign force_vec = (bus_wr_i && sel == SEL_FORCE) ? wvec : '0;
   assign mset_vec  = (bus_wr_i && sel == SEL_MSET)  ? wvec : '0;
   assign mclr_vec  = (bus_wr_i && sel == SEL_MCLR)  ? wvec : '0;

   l2irq_pending #(
      .NUM_SRC    (NUM_SRC),
      .LEVEL_MODE (LEVEL_MODE)
   ) u_pending (
      .clk       (clk),
      .rst_n     (rst_n),
      .src       (src_i),
      .ack_vec   (ack_vec),
      .force_vec (force_vec),
      .pend      (pend)
   );

   l2irq_mask #(
      .NUM_SRC (NUM_SRC)
   ) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (mset_vec),
      .clr_vec (mclr_vec),
      .mask    (mask)
   );

   always_comb begin
      rd_word = '0;
      if (sel_readable(sel)) begin
         if (sel == SEL_PEND) begin
            rd_word[NUM_SRC-1:0] = pend;
         end else begin
            rd_word[NUM_SRC-1:0] = mask;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
         irq_q   <= 1'b0;
      end else begin
         rdata_q <= bus_rd_i ? rd_word : '0;
         irq_q   <= |(pend & ~mask);
      end
   end

   assign bus_rdata_o = rdata_q;
   assign irq_o       = irq_q;

   // R10: no read strobe, no read data
   a_r10_idle_read_zero : assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_i |=> (bus_rdata_o == '0));

   // R7: with every source masked the parent line drops
   a_r7_all_masked_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      (&mask) |=> !irq_o);

   // R7: nothing pending means no parent interrupt next cycle
   a_r7_none_pending_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      (pend == '0) |=> !irq_o);

   // R9: a write with no decoded target leaves the mask unchanged
   a_r9_stray_write_ignored : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_i && sel == SEL_NONE) |=> $stable(mask));

endmodule

// File: tb/sim_l2irq_ctrl.sv
module sim_l2irq_ctrl;

   localparam int N = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src = '0;
   logic [7:0]  addr = '0;
   logic        wr = 1'b0;
   logic        rd = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata_e, rdata_l;
   logic        irq_e, irq_l;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [31:0] m_pend = '0;
   logic [31:0] m_prev = '0;
   logic [31:0] m_mask_e = '1;
   logic [31:0] m_mask_l = '1;
   logic [31:0] x_rd_e = '0, x_rd_l = '0;
   logic        x_irq_e = 1'b0, x_irq_l = 1'b0;

   always #10 clk = ~clk;

   l2irq_ctrl #(.NUM_SRC(N), .DATA_W(32), .ADDR_W(8), .LEVEL_MODE(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr_i(addr), .bus_wr_i(wr),
      .bus_rd_i(rd), .bus_wdata_i(wdata), .bus_rdata_o(rdata_e), .irq_o(irq_e));

   l2irq_ctrl #(.NUM_SRC(N), .DATA_W(32), .ADDR_W(8), .LEVEL_MODE(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr_i(addr), .bus_wr_i(wr),
      .bus_rd_i(rd), .bus_wdata_i(wdata), .bus_rdata_o(rdata_l), .irq_o(irq_l));

   function automatic logic [31:0] read_val(bit lvl, logic [7:0] a,
                                            logic [31:0] st, logic [31:0] mk);
      if (!lvl) begin
         if (a == 8'h00) return st;
         if (a == 8'h0C) return mk;
      end else begin
         if (a == 8'h00) return st;
         if (a == 8'h04) return mk;
      end
      return '0;
   endfunction

   function automatic string read_tag(bit lvl, logic [7:0] a);
      if (a == 8'h00) return lvl ? "R8" : "R2";
      if ((!lvl && a == 8'h0C) || (lvl && a == 8'h04)) return "R6";
      return "R9";
   endfunction

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // One clock: model update at the edge, compare at the following negedge
   task automatic cyc(string tag);
      logic [31:0] ack, frc, mse, mce, msl, mcl, rise;
      string rt_e, rt_l;
      @(posedge clk);
      rt_e = rd ? read_tag(1'b0, addr) : "R10";
      rt_l = rd ? read_tag(1'b1, addr) : "R10";
      x_rd_e  = rd ? read_val(1'b0, addr, m_pend, m_mask_e) : '0;
      x_rd_l  = rd ? read_val(1'b1, addr, src, m_mask_l) : '0;
      x_irq_e = |(m_pend & ~m_mask_e);
      x_irq_l = |(src & ~m_mask_l);
      ack = (wr && addr == 8'h08) ? wdata : '0;
      frc = (wr && addr == 8'h04) ? wdata : '0;
      mse = (wr && addr == 8'h10) ? wdata : '0;
      mce = (wr && addr == 8'h14) ? wdata : '0;
      msl = (wr && addr == 8'h08) ? wdata : '0;
      mcl = (wr && addr == 8'h0C) ? wdata : '0;
      rise = src & ~m_prev;
      m_pend   = (m_pend & ~ack) | frc | rise;
      m_prev   = src;
      m_mask_e = (m_mask_e | mse) & ~mce;
      m_mask_l = (m_mask_l | msl) & ~mcl;
      @(negedge clk);
      check({tag, "/", rt_e, "/R10"}, "latched rdata", rdata_e, x_rd_e);
      check({tag, "/", rt_l, "/R10"}, "level rdata", rdata_l, x_rd_l);
      check({tag, "/R7"}, "latched irq", {31'b0, irq_e}, {31'b0, x_irq_e});
      check({tag, "/R7"}, "level irq", {31'b0, irq_l}, {31'b0, x_irq_l});
   endtask

   task automatic bus(string tag, bit w, bit r, logic [7:0] a, logic [31:0] d);
      wr = w; rd = r; addr = a; wdata = d;
      cyc(tag);
      wr = 1'b0; rd = 1'b0;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=running expected=done");
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1: reset state on the ports
      check("R1", "latched rdata in reset", rdata_e, '0);
      check("R1", "level irq in reset", {31'b0, irq_l}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      bus("R1", 0, 1, 8'h0C, '0);    // latched mask status all ones
      bus("R1", 0, 1, 8'h04, '0);    // level mask status all ones
      bus("R1", 0, 1, 8'h00, '0);    // no pending after reset
      // R2: single pulse on bit 3 stays latched
      src[3] = 1'b1; cyc("R2");
      src[3] = 1'b0; cyc("R2");
      bus("R2", 0, 1, 8'h00, '0);
      // R3: ack with a zero at bit 3 leaves it; then ack bit 3
      bus("R3", 1, 0, 8'h08, 32'h0000_0001);
      bus("R3", 0, 1, 8'h00, '0);
      bus("R3", 1, 0, 8'h08, 32'h0000_0008);
      bus("R3", 0, 1, 8'h00, '0);
      // R4: software force
      bus("R4", 1, 0, 8'h04, 32'hA500_0000);
      bus("R4", 0, 1, 8'h00, '0);
      // R5: edge and ack on bit 7 in the same cycle
      src[7] = 1'b1;
      bus("R5", 1, 0, 8'h08, 32'h0000_0080);
      bus("R5", 0, 1, 8'h00, '0);
      src[7] = 1'b0;
      // R6 / R7: unmask a forced bit in latched mode, parent fires
      bus("R6", 1, 0, 8'h14, 32'h0100_0000);
      bus("R7", 0, 1, 8'h0C, '0);
      cyc("R7");
      bus("R6", 1, 0, 8'h10, 32'hFFFF_FFFF);
      cyc("R7");
      // R8: level mode unmask and follow inputs
      bus("R8", 1, 0, 8'h0C, 32'h0000_00F0);
      src[5] = 1'b1; cyc("R8");
      bus("R8", 0, 1, 8'h00, '0);
      src[5] = 1'b0;
      bus("R8", 0, 1, 8'h00, '0);
      // R9: stray writes and reads
      bus("R9", 1, 0, 8'h00, '0);
      bus("R9", 1, 0, 8'h40, 32'hFFFF_FFFF);
      bus("R9", 1, 0, 8'h16, 32'hFFFF_FFFF);
      bus("R9", 0, 1, 8'h40, '0);
      bus("R9", 0, 1, 8'h02, '0);
      bus("R9", 0, 1, 8'h14, '0);
      // R10: read with same-cycle write shows old value (single strobe pair)
      wr = 1'b1; rd = 1'b1; addr = 8'h14; wdata = 32'h0000_FFFF;
      cyc("R10");
      wr = 1'b0; rd = 1'b0;
      bus("R10", 0, 1, 8'h0C, '0);
      // Random traffic
      for (int i = 0; i < 3000; i++) begin
         logic [7:0] offs [9] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14,
                                  8'h18, 8'h40, 8'h02};
         int r = $urandom_range(0, 99);
         if ($urandom_range(0, 3) == 0) src = $urandom;
         wr = (r < 30);
         rd = (r >= 30 && r < 75);
         addr = offs[$urandom_range(0, 8)];
         wdata = $urandom;
         cyc("RND");
      end
      wr = 1'b0; rd = 1'b0;
      cyc("RND");
      done = 1'b1;
      finish_run();
   end

endmodule